// File: doc/BRIEF.md
# Banked CPU Register File with Memory Aliasing

This block is the general-purpose register store of a small 8-bit processor core. It holds four banks of eight byte-wide registers. At any moment one bank is the working bank. The CPU port reads and writes in that bank only. It can reach a single byte, or a 16-bit pair built from two neighbouring bytes. A bank-select input, driven when the core executes its bank-switch instruction, chooses the working bank.

The same 32 bytes also appear in the data-memory space, in a fixed window from FEE0H to FEFFH. A memory port can read or write any byte of any bank through this window, whatever the working bank is. The block reports whether a memory address falls inside its window, so the surrounding memory system can route the access. Everything else in the data memory, instruction decode and interrupt logic lies outside this block.

Banks sit in the window in reverse order. Bank 0 is at the top, FEF8H–FEFFH, and bank 3 is at the bottom, FEE0H–FEE7H. Register n of a bank is at base+n, so every pair is stored low byte first.

Top module: `bank_regfile`

## Requirements
- R1: While the reset is asserted, and afterwards until the first write, every register reads 0 and the working bank is bank 0.
- R2: A bank-select (`bank_sel_we`=1 with `bank_sel_num`) changes the working bank from the next clock edge. A CPU access in the same cycle still uses the old bank.
- R3: When `cpu_wide`=0, `cpu_rdata` is {8'h00, register `cpu_idx`} of the working bank. It is combinational and appears in the same cycle.
- R4: A byte write (`cpu_we`=1, `cpu_wide`=0) stores the low byte of `cpu_wdata` into register `cpu_idx` of the working bank. The new value is visible after the next clock edge, and no other register changes.
- R5: When `cpu_wide`=1, pair p = `cpu_idx[1:0]` is read as {register 2p+1, register 2p}. Register 2p+1 is the high byte, so pair 0 is (R1,R0). `cpu_idx[2]` is ignored.
- R6: A pair write (`cpu_we`=1, `cpu_wide`=1) updates both bytes of pair p in one clock edge. `cpu_wdata[7:0]` goes to register 2p and `cpu_wdata[15:8]` goes to register 2p+1.
- R7: `mem_hit` is 1 exactly when `mem_addr` is in FEE0H–FEFFH.
- R8: A window address a maps to bank 3-((a-FEE0H)>>3) and register (a-FEE0H)&7. `mem_rdata` returns that byte, whichever bank is the working bank.
- R9: A memory write with `mem_hit`=1 stores `mem_wdata` into the mapped byte, visible after the next edge. A memory write outside the window changes nothing.
- R10: When the CPU port and the memory port write the same byte in one cycle, the CPU value is stored.
- R11: `mem_rdata` is 0 whenever `mem_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel_we | input | 1 | Bank-switch strobe |
| bank_sel_num | input | 2 | New working bank number |
| cpu_we | input | 1 | CPU write enable |
| cpu_wide | input | 1 | 1 selects a 16-bit pair, 0 a single byte |
| cpu_idx | input | 3 | Register index, or pair index in bits 1:0 |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data from the working bank |
| mem_addr | input | 16 | Data-memory address |
| mem_we | input | 1 | Data-memory write enable |
| mem_wdata | input | 8 | Data-memory write byte |
| mem_hit | output | 1 | Address is inside the register window |
| mem_rdata | output | 8 | Byte read through the window |

## Verification
Both read paths and `mem_hit` are combinational, so each is due in the same cycle as the address or index that selects it. The bench drives inputs on the falling edge and compares these outputs one time unit later, before the rising edge. Writes and bank switches take effect at the next rising edge. The reference model commits them only after that edge, so their results are checked one cycle after the stimulus. After reset is released, the internal synchroniser adds two more cycles, and the bench keeps both ports idle during that time.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned DFLT_BANKS    = 4;
  localparam int unsigned DFLT_REGS     = 8;
  localparam int unsigned DFLT_DATA_W   = 8;
  localparam int unsigned DFLT_ADDR_W   = 16;
  localparam logic [15:0] DFLT_WIN_BASE = 16'hFEE0;
endpackage

// File: rtl/regfile_rst_sync.sv
module regfile_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/regfile_win_decode.sv
module regfile_win_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] WIN_BASE  = 16'hFEE0,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned REGS      = 8,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned REG_W    = $clog2(REGS),
  localparam int unsigned IDX_W    = BANK_W + REG_W,
  localparam int unsigned ENTRIES  = NUM_BANKS * REGS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  entry
);
  logic [ADDR_W-1:0] offset;
  logic [BANK_W-1:0] slot;
  logic [BANK_W-1:0] bank;

  always_comb begin
    offset = addr - ADDR_W'(WIN_BASE);
    hit    = offset < ADDR_W'(ENTRIES);
    slot   = offset[IDX_W-1:REG_W];
    bank   = BANK_W'(NUM_BANKS - 1) - slot;
    entry  = {bank, offset[REG_W-1:0]};
  end
endmodule

// File: rtl/regfile_bank_ctl.sv
module regfile_bank_ctl #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [BANK_W-1:0] sel_num,
  output logic [BANK_W-1:0] cur_bank
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;
  logic              bank_en;

  always_comb begin
    bank_en = sel_we;
    bank_d  = sel_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assign cur_bank = bank_q;

  // R2
  bank_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> cur_bank == $past(sel_num));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(cur_bank));
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            lo_we,
  input  logic [IDX_W-1:0]                lo_idx,
  input  logic [DATA_W-1:0]               lo_data,
  input  logic                            hi_we,
  input  logic [IDX_W-1:0]                hi_idx,
  input  logic [DATA_W-1:0]               hi_data,
  input  logic                            mw_we,
  input  logic [IDX_W-1:0]                mw_idx,
  input  logic [DATA_W-1:0]               mw_data,
  output logic [ENTRIES-1:0][DATA_W-1:0]  cells
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    logic [DATA_W-1:0] cell_d;
    logic              cell_en;
    logic              sel_lo;
    logic              sel_hi;
    logic              sel_mw;

    always_comb begin
      sel_lo  = lo_we && (lo_idx == IDX_W'(e));
      sel_hi  = hi_we && (hi_idx == IDX_W'(e));
      sel_mw  = mw_we && (mw_idx == IDX_W'(e));
      cell_en = sel_lo || sel_hi || sel_mw;
      cell_d  = cell_q;
      if (sel_mw) cell_d = mw_data;
      if (sel_hi) cell_d = hi_data;
      if (sel_lo) cell_d = lo_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_en) cell_q <= cell_d;
    end

    assign cells[e] = cell_q;

    // R10
    cpu_lo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && lo_idx == IDX_W'(e)) |=> cells[e] == $past(lo_data));

    // R6
    cpu_hi_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && hi_idx == IDX_W'(e)) |=> cells[e] == $past(hi_data));

    // R9
    mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_we && mw_idx == IDX_W'(e) && !(lo_we && lo_idx == IDX_W'(e))
       && !(hi_we && hi_idx == IDX_W'(e))) |=> cells[e] == $past(mw_data));
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned NUM_BANKS = DFLT_BANKS,
  parameter int unsigned REGS      = DFLT_REGS,
  parameter int unsigned DATA_W    = DFLT_DATA_W,
  parameter int unsigned ADDR_W    = DFLT_ADDR_W,
  parameter logic [15:0] WIN_BASE  = DFLT_WIN_BASE,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned REG_W    = $clog2(REGS),
  localparam int unsigned PAIR_W   = REG_W - 1,
  localparam int unsigned IDX_W    = BANK_W + REG_W,
  localparam int unsigned ENTRIES  = NUM_BANKS * REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_sel_we,
  input  logic [BANK_W-1:0]   bank_sel_num,
  input  logic                cpu_we,
  input  logic                cpu_wide,
  input  logic [REG_W-1:0]    cpu_idx,
  input  logic [2*DATA_W-1:0] cpu_wdata,
  output logic [2*DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_hit,
  output logic [DATA_W-1:0]   mem_rdata
);
  logic                           rst_n_s;
  logic [BANK_W-1:0]              work_bank;
  logic [IDX_W-1:0]               win_entry;
  logic                           win_hit;
  logic [IDX_W-1:0]               lo_entry;
  logic [IDX_W-1:0]               hi_entry;
  logic [ENTRIES-1:0][DATA_W-1:0] cells;

  regfile_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  regfile_bank_ctl #(.NUM_BANKS(NUM_BANKS)) i_bank_ctl (
    .clk(clk), .rst_n(rst_n_s), .sel_we(bank_sel_we),
    .sel_num(bank_sel_num), .cur_bank(work_bank)
  );

  regfile_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NUM_BANKS(NUM_BANKS), .REGS(REGS)
  ) i_win_decode (
    .addr(mem_addr), .hit(win_hit), .entry(win_entry)
  );

  always_comb begin
    if (cpu_wide) lo_entry = {work_bank, cpu_idx[PAIR_W-1:0], 1'b0};
    else          lo_entry = {work_bank, cpu_idx};
    hi_entry = {work_bank, cpu_idx[PAIR_W-1:0], 1'b1};
  end

  regfile_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n_s),
    .lo_we(cpu_we), .lo_idx(lo_entry), .lo_data(cpu_wdata[DATA_W-1:0]),
    .hi_we(cpu_we && cpu_wide), .hi_idx(hi_entry),
    .hi_data(cpu_wdata[2*DATA_W-1:DATA_W]),
    .mw_we(mem_we && win_hit), .mw_idx(win_entry), .mw_data(mem_wdata),
    .cells(cells)
  );

  always_comb begin
    if (cpu_wide) cpu_rdata = {cells[hi_entry], cells[lo_entry]};
    else          cpu_rdata = {{DATA_W{1'b0}}, cells[lo_entry]};
    mem_hit   = win_hit;
    mem_rdata = win_hit ? cells[win_entry] : '0;
  end

  // R11
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mem_hit |-> mem_rdata == '0);

  // R3
  byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cpu_wide |-> cpu_rdata[2*DATA_W-1:DATA_W] == '0);

  // R4
  cpu_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_we && !cpu_wide && !bank_sel_we) |=>
      (!cpu_wide && cpu_idx == $past(cpu_idx)) ->
        cpu_rdata[DATA_W-1:0] == $past(cpu_wdata[DATA_W-1:0]));
endmodule

// File: tb/test_bank_regfile.sv
module test_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bank_sel_we;
  logic [1:0]  bank_sel_num;
  logic        cpu_we;
  logic        cpu_wide;
  logic [2:0]  cpu_idx;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_hit;
  logic [7:0]  mem_rdata;

  int errors = 0;
  int checks = 0;
  int model [4][8];
  int abank = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_regfile i_bank_regfile (
    .clk(clk), .rst_n(rst_n), .bank_sel_we(bank_sel_we),
    .bank_sel_num(bank_sel_num), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
    .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_hit(mem_hit), .mem_rdata(mem_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bank_sel_we = 0; bank_sel_num = 0; cpu_we = 0; cpu_wide = 0;
    cpu_idx = 0; cpu_wdata = 0; mem_addr = 16'h0000; mem_we = 0; mem_wdata = 0;
  endtask

  // Compare against the model before the edge, then commit the model after it.
  task automatic step(input string ph);
    int a, off, b, n, p, e_cpu, e_mem;
    bit e_hit;
    #1;
    a = int'(mem_addr);
    e_hit = (a >= 'hFEE0) && (a <= 'hFEFF);
    off = a - 'hFEE0;
    b = 3 - off / 8;
    n = off % 8;
    e_mem = e_hit ? model[b][n] : 0;
    if (cpu_wide) begin
      p = int'(cpu_idx) % 4;
      e_cpu = model[abank][2*p+1] * 256 + model[abank][2*p];
    end else begin
      e_cpu = model[abank][cpu_idx];
    end
    check({ph, " R7 mem_hit"}, int'(mem_hit), int'(e_hit));
    check({ph, e_hit ? " R8 mem_rdata" : " R11 mem_rdata"}, int'(mem_rdata), e_mem);
    check({ph, cpu_wide ? " R5 pair read" : " R3 byte read"}, int'(cpu_rdata), e_cpu);
    @(posedge clk);
    if (rst_n) begin
      if (mem_we && e_hit) model[b][n] = int'(mem_wdata);
      if (cpu_we) begin
        if (cpu_wide) begin
          p = int'(cpu_idx) % 4;
          model[abank][2*p]   = int'(cpu_wdata[7:0]);
          model[abank][2*p+1] = int'(cpu_wdata[15:8]);
        end else begin
          model[abank][cpu_idx] = int'(cpu_wdata[7:0]);
        end
      end
      if (bank_sel_we) abank = int'(bank_sel_num);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int n = 0; n < 8; n++) model[b][n] = 0;
    idle();
    rst_n = 0;
    @(negedge clk);
    // R1: all reads zero while reset is held
    for (int i = 0; i < 3; i++) begin cpu_idx = 3'(i); step("R1 in reset"); end
    rst_n = 1;
    for (int i = 0; i < 3; i++) step("R1 sync release");
    // R1: sweep the window after reset
    for (int i = 0; i < 32; i++) begin mem_addr = 16'hFEE0 + 16'(i); step("R1 window sweep"); end
    // R9: fill every byte through the window with distinct values
    for (int i = 0; i < 32; i++) begin
      mem_addr = 16'hFEE0 + 16'(i); mem_we = 1; mem_wdata = 8'(i * 7 + 3);
      step("R9 fill");
    end
    idle();
    // R1, R3: working bank is 0 after reset (reads top 8 bytes of window)
    for (int i = 0; i < 8; i++) begin cpu_idx = 3'(i); step("R1 bank0 bytes"); end
    // R5: pair reads, upper index bit ignored
    cpu_wide = 1;
    for (int i = 0; i < 8; i++) begin cpu_idx = 3'(i); step("R5 pairs"); end
    // R9: writes just outside the window change nothing
    cpu_wide = 0; mem_we = 1; mem_wdata = 8'hEE;
    mem_addr = 16'hFEDF; step("R9 below window");
    mem_addr = 16'hFF00; step("R9 above window");
    mem_we = 0;
    mem_addr = 16'hFEE0; step("R9 low edge");
    mem_addr = 16'hFEFF; step("R9 high edge");
    // R2: switch to bank 2 while reading; same-cycle read uses bank 0
    bank_sel_we = 1; bank_sel_num = 2; cpu_idx = 5; step("R2 switch cycle");
    bank_sel_we = 0; step("R2 after switch");
    // R4: byte write in bank 2, other bytes kept
    cpu_we = 1; cpu_idx = 4; cpu_wdata = 16'h3C91; step("R4 byte write");
    cpu_we = 0;
    for (int i = 0; i < 8; i++) begin cpu_idx = 3'(i); step("R4 readback"); end
    // R8: memory reads independent of working bank (bank 2 at FEE8)
    for (int i = 0; i < 8; i++) begin mem_addr = 16'hFEE8 + 16'(i); step("R8 alias"); end
    // R6: pair write updates both bytes
    cpu_we = 1; cpu_wide = 1; cpu_idx = 3; cpu_wdata = 16'hA55A; step("R6 pair write");
    cpu_we = 0; mem_addr = 16'hFEEE; step("R6 low byte in memory");
    mem_addr = 16'hFEEF; step("R6 high byte in memory");
    // R10: same-byte conflict, CPU wins (bank 2 reg 6 at FEEE)
    cpu_we = 1; cpu_wide = 0; cpu_idx = 6; cpu_wdata = 16'h0011;
    mem_we = 1; mem_addr = 16'hFEEE; mem_wdata = 8'h99; step("R10 conflict");
    cpu_we = 0; mem_we = 0; step("R10 readback");
    // R10 with a pair write overlapping the memory byte on the high half
    cpu_we = 1; cpu_wide = 1; cpu_idx = 0; cpu_wdata = 16'h7788;
    mem_we = 1; mem_addr = 16'hFEE9; mem_wdata = 8'h42; step("R10 pair conflict");
    cpu_we = 0; mem_we = 0; step("R10 pair readback");
    // Mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bank_sel_we  = ($urandom % 8) == 0;
      bank_sel_num = 2'($urandom);
      cpu_we       = ($urandom % 3) == 0;
      cpu_wide     = 1'($urandom);
      cpu_idx      = 3'($urandom);
      cpu_wdata    = 16'($urandom);
      mem_we       = ($urandom % 3) == 0;
      mem_wdata    = 8'($urandom);
      if (($urandom % 4) != 0) mem_addr = 16'hFEE0 + 16'($urandom % 32);
      else                     mem_addr = 16'hFED0 + 16'($urandom % 64);
      step("R2 R4 R6 R9 R10 mixed");
    end
    idle();
    step("final");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule